// File: doc/BRIEF.md
# Byte ALU with status flags

This block is the purely combinational arithmetic and logic stage of a small accumulator-style processor core. Each cycle the surrounding datapath presents an operation code, the working byte `w_opd`, a second byte `f_opd` (taken from a data register or an instruction literal), and the current carry, digit-carry and overflow flags. Within the same cycle the block returns an 8-bit result, a 16-bit product split into two bytes, a single compare-outcome bit, and the next values of the C, DC, Z, OV and N flags.

Arithmetic covers plain and carry-chained addition and subtraction, two's-complement negation and packed-BCD decimal adjustment. Logic covers AND, OR, XOR, bitwise inversion, four rotate forms and a nibble exchange. An unsigned byte multiply and three unsigned compares complete the set. Carry chaining across bytes works by feeding `c_out` of one operation back as `c_in` of the next. The caller owns all flag storage, so operations that preserve a flag simply copy its input to its output.

Top module: `byte_alu`

## Requirements
- R1: Code 0 (add) gives result = f + w and code 1 (add with carry) gives f + w + c_in. C is the ninth bit of the sum and DC is the carry out of bit 3.
- R2: For codes 0 to 4, OV is 1 exactly when the adder's two inputs share a sign bit and the 8-bit sum has the other sign. This equals the carry into bit 7 differing from the carry out of bit 7.
- R3: Code 2 (subtract) gives f + ~w + 1 and code 3 (subtract with borrow) gives f + ~w + c_in, so C = 1 means no borrow. C and DC come from the same adder carries as in R1.
- R4: Code 4 (negate) gives 0 + ~f + 1, with C, DC and OV from that addition. Code 5 (complement) gives ~f.
- R5: Codes 6, 7 and 8 give f AND w, f OR w and f XOR w. For codes 5 to 10, 13 and 15, c_out, dc_out and ov_out equal c_in, dc_in and ov_in.
- R6: Code 9 rotates f right by one and code 10 rotates it left, both within 8 bits. Code 11 gives {c_in, f[7:1]} with C = f[0]. Code 12 gives {f[6:0], c_in} with C = f[7].
- R7: Code 13 gives {f[3:0], f[7:4]}.
- R8: Code 14 adjusts w as packed BCD. It first adds 6 when w[3:0] > 9 or dc_in = 1. It then adds 0x60 when the upper nibble of that sum is greater than 9, when c_in = 1, or when the first step carried. C becomes c_in OR any carry from these steps. DC and OV are held.
- R9: Code 15 gives {prod_hi, prod_lo} = w * f (unsigned), with result = prod_lo. For every other code prod_hi and prod_lo are 0.
- R10: Codes 16, 17 and 18 set cmp_hit when f > w, f == w and f < w respectively, all as unsigned values. cmp_hit is 0 for every other code. Compare codes pass f to result and hold C, DC and OV.
- R11: For every code, z_out = (result == 0) and n_out = result[7]. Codes 19 to 31 pass f to result and hold C, DC and OV.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 5 | Operation code (see requirements) |
| w_opd | input | 8 | Working operand |
| f_opd | input | 8 | Register or literal operand |
| c_in | input | 1 | Incoming carry flag |
| dc_in | input | 1 | Incoming digit-carry flag |
| ov_in | input | 1 | Incoming overflow flag |
| result | output | 8 | Byte result |
| prod_hi | output | 8 | Product upper byte |
| prod_lo | output | 8 | Product lower byte |
| cmp_hit | output | 1 | Compare condition true |
| c_out | output | 1 | Next carry flag |
| dc_out | output | 1 | Next digit-carry flag |
| z_out | output | 1 | Next zero flag |
| ov_out | output | 1 | Next overflow flag |
| n_out | output | 1 | Next negative flag |

## Verification
The hardest case to reach is the decimal adjust with both correction steps taken for different reasons. One such case is a low-nibble fix that ripples into an upper nibble of A and then wraps to zero with a carry. Another is an incoming C that forces the upper fix on a value that needs none. Neither case comes from ordinary BCD sums. The stimulus therefore drives the adjust code directly with crafted working values (0x9A, and 0x23 with both incoming flags set), and it uses a sweep of adder operands that crosses the bit-3 and bit-7 carry boundaries under all carry-in values.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBB = 5'd3,
    OP_NEG  = 5'd4,
    OP_COM  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_RRN  = 5'd9,
    OP_RLN  = 5'd10,
    OP_RRC  = 5'd11,
    OP_RLC  = 5'd12,
    OP_SWAP = 5'd13,
    OP_DADJ = 5'd14,
    OP_MUL  = 5'd15,
    OP_CGT  = 5'd16,
    OP_CEQ  = 5'd17,
    OP_CLT  = 5'd18
  } alu_op_e;
endpackage

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          co,
  output logic          half_co,
  output logic          ov
);
  localparam int HALF = DW / 2;

  logic [DW:0] cy;
  assign cy[0] = cin;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign sum[i]  = a[i] ^ b[i] ^ cy[i];
    assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
  end

  assign co      = cy[DW];
  assign half_co = cy[HALF];
  assign ov      = cy[DW] ^ cy[DW-1];

  always_comb begin
    // R1: ripple chain matches integer addition
    a_r1_sum: assert ({co, sum} == ({1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin}))
      else $error("adder sum mismatch");
    // R2: overflow by sign rule
    a_r2_ov_sign: assert (ov == ((a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1])))
      else $error("adder overflow mismatch");
  end
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [2*DW-1:0] prod
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] acc [DW+1];
  assign acc[0] = '0;

  for (genvar i = 0; i < DW; i++) begin : g_row
    logic [PW-1:0] part;
    assign part       = b[i] ? ({{DW{1'b0}}, a} << i) : '0;
    assign acc[i+1]   = acc[i] + part;
  end

  assign prod = acc[DW];

  always_comb begin
    // R9: shift-add array equals unsigned product
    a_r9_product: assert (prod == ({{DW{1'b0}}, a} * {{DW{1'b0}}, b}))
      else $error("multiplier mismatch");
  end
endmodule

// File: rtl/bcd_adjust.sv
module bcd_adjust
  import alu_pkg::*;
(
  input  logic [BYTE_W-1:0] val,
  input  logic              dc_in,
  input  logic              c_in,
  output logic [BYTE_W-1:0] adj,
  output logic              co
);
  localparam logic [NIB_W-1:0] DIG_MAX = NIB_W'(9);
  localparam logic [BYTE_W:0]  LO_SIX  = (BYTE_W+1)'(6);
  localparam logic [BYTE_W:0]  HI_SIX  = (BYTE_W+1)'(6) << NIB_W;

  logic            lo_fix, hi_fix;
  logic [BYTE_W:0] stage1, stage2;

  always_comb begin
    lo_fix = (val[NIB_W-1:0] > DIG_MAX) || dc_in;
    stage1 = {1'b0, val} + (lo_fix ? LO_SIX : '0);
    hi_fix = (stage1[BYTE_W-1:NIB_W] > DIG_MAX) || c_in || stage1[BYTE_W];
    stage2 = {1'b0, stage1[BYTE_W-1:0]} + (hi_fix ? HI_SIX : '0);
  end

  assign adj = stage2[BYTE_W-1:0];
  assign co  = stage1[BYTE_W] | stage2[BYTE_W];

  always_comb begin
    // R8: valid BCD with no incoming flags passes unchanged
    if ((val[NIB_W-1:0] <= DIG_MAX) && (val[BYTE_W-1:NIB_W] <= DIG_MAX) && !dc_in && !c_in)
      a_r8_bcd_identity: assert ((adj == val) && !co)
        else $error("decimal adjust altered valid BCD");
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import alu_pkg::*;
(
  input  logic [4:0] op,
  input  logic [7:0] w_opd,
  input  logic [7:0] f_opd,
  input  logic       c_in,
  input  logic       dc_in,
  input  logic       ov_in,
  output logic [7:0] result,
  output logic [7:0] prod_hi,
  output logic [7:0] prod_lo,
  output logic       cmp_hit,
  output logic       c_out,
  output logic       dc_out,
  output logic       z_out,
  output logic       ov_out,
  output logic       n_out
);
  localparam int MSB = BYTE_W - 1;

  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  // adder operand selection
  logic [BYTE_W-1:0] add_a, add_b, add_sum;
  logic              add_ci, add_co, add_dc, add_ov, is_arith;

  always_comb begin
    add_a    = f_opd;
    add_b    = w_opd;
    add_ci   = 1'b0;
    is_arith = 1'b1;
    unique case (op_e)
      OP_ADD:  ;
      OP_ADDC: add_ci = c_in;
      OP_SUB:  begin add_b = ~w_opd; add_ci = 1'b1; end
      OP_SUBB: begin add_b = ~w_opd; add_ci = c_in; end
      OP_NEG:  begin add_a = '0; add_b = ~f_opd; add_ci = 1'b1; end
      default: is_arith = 1'b0;
    endcase
  end

  ripple_adder #(.DW(BYTE_W)) u_add (
    .a(add_a), .b(add_b), .cin(add_ci),
    .sum(add_sum), .co(add_co), .half_co(add_dc), .ov(add_ov)
  );

  logic [2*BYTE_W-1:0] mul_p;
  shift_add_mult #(.DW(BYTE_W)) u_mul (.a(w_opd), .b(f_opd), .prod(mul_p));

  logic [BYTE_W-1:0] dadj_v;
  logic              dadj_co;
  bcd_adjust u_dadj (.val(w_opd), .dc_in(dc_in), .c_in(c_in), .adj(dadj_v), .co(dadj_co));

  // result and flag selection
  always_comb begin
    result  = f_opd;
    c_out   = c_in;
    dc_out  = dc_in;
    ov_out  = ov_in;
    cmp_hit = 1'b0;
    prod_hi = '0;
    prod_lo = '0;
    if (is_arith) begin
      result = add_sum;
      c_out  = add_co;
      dc_out = add_dc;
      ov_out = add_ov;
    end
    unique case (op_e)
      OP_COM:  result = ~f_opd;
      OP_AND:  result = f_opd & w_opd;
      OP_OR:   result = f_opd | w_opd;
      OP_XOR:  result = f_opd ^ w_opd;
      OP_RRN:  result = {f_opd[0], f_opd[MSB:1]};
      OP_RLN:  result = {f_opd[MSB-1:0], f_opd[MSB]};
      OP_RRC:  begin result = {c_in, f_opd[MSB:1]}; c_out = f_opd[0]; end
      OP_RLC:  begin result = {f_opd[MSB-1:0], c_in}; c_out = f_opd[MSB]; end
      OP_SWAP: result = {f_opd[NIB_W-1:0], f_opd[MSB:NIB_W]};
      OP_DADJ: begin result = dadj_v; c_out = c_in | dadj_co; end
      OP_MUL:  begin
        prod_hi = mul_p[2*BYTE_W-1:BYTE_W];
        prod_lo = mul_p[BYTE_W-1:0];
        result  = mul_p[BYTE_W-1:0];
      end
      OP_CGT:  cmp_hit = (f_opd > w_opd);
      OP_CEQ:  cmp_hit = (f_opd == w_opd);
      OP_CLT:  cmp_hit = (f_opd < w_opd);
      default: ;
    endcase
    z_out = ~|result;
    n_out = result[MSB];
  end

  logic flag_hold_op;
  assign flag_hold_op = (op_e == OP_COM) || (op_e == OP_AND) || (op_e == OP_OR) ||
                        (op_e == OP_XOR) || (op_e == OP_RRN) || (op_e == OP_RLN) ||
                        (op_e == OP_SWAP) || (op_e == OP_MUL);

  always_comb begin
    // R5: logic-class operations leave C, DC, OV untouched
    if (flag_hold_op)
      a_r5_flags_held: assert ((c_out == c_in) && (dc_out == dc_in) && (ov_out == ov_in))
        else $error("flag changed by logic operation");
    // R10: compare outcome only on compare codes
    if (op > 5'd18 || op < 5'd16)
      a_r10_cmp_quiet: assert (!cmp_hit) else $error("compare hit outside compare op");
    // R9: product bytes stay zero except on multiply
    if (op != 5'd15)
      a_r9_prod_quiet: assert ((prod_hi == '0) && (prod_lo == '0))
        else $error("product driven outside multiply");
    // R6: through-carry rotates keep all nine bits
    if (op == 5'd11 || op == 5'd12)
      a_r6_ninebit: assert ($countones({c_out, result}) == $countones({c_in, f_opd}))
        else $error("rotate through carry lost a bit");
  end
endmodule

// File: tb/tb_byte_alu.sv
module tb_byte_alu;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;
  localparam int WATCHDOG = 100000;

  logic       clk;
  logic [4:0] op;
  logic [7:0] w_opd, f_opd;
  logic       c_in, dc_in, ov_in;
  logic [7:0] result, prod_hi, prod_lo;
  logic       cmp_hit, c_out, dc_out, z_out, ov_out, n_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  byte_alu dut (
    .op(op), .w_opd(w_opd), .f_opd(f_opd), .c_in(c_in), .dc_in(dc_in), .ov_in(ov_in),
    .result(result), .prod_hi(prod_hi), .prod_lo(prod_lo), .cmp_hit(cmp_hit),
    .c_out(c_out), .dc_out(dc_out), .z_out(z_out), .ov_out(ov_out), .n_out(n_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // vector: op, w, f, c, dc, ov | res, hi, lo, cmp, c, dc, z, ov, n
  localparam logic [53:0] VECS [NV] = '{
    {5'd0,  8'hE7, 8'h8D, 3'b000, 8'h74, 8'h00, 8'h00, 6'b011010}, // R1 R2 low byte
    {5'd1,  8'h3C, 8'h3B, 3'b100, 8'h78, 8'h00, 8'h00, 6'b001000}, // R1 chained byte
    {5'd0,  8'h25, 8'h47, 3'b000, 8'h6C, 8'h00, 8'h00, 6'b000000}, // R1
    {5'd14, 8'h6C, 8'h00, 3'b000, 8'h72, 8'h00, 8'h00, 6'b000000}, // R8 low fix
    {5'd14, 8'h9A, 8'h00, 3'b001, 8'h00, 8'h00, 8'h00, 6'b010110}, // R8 both fix, wrap
    {5'd14, 8'h23, 8'h00, 3'b110, 8'h89, 8'h00, 8'h00, 6'b011001}, // R8 flag-forced
    {5'd2,  8'h05, 8'h03, 3'b000, 8'hFE, 8'h00, 8'h00, 6'b000001}, // R3 borrow
    {5'd2,  8'h03, 8'h03, 3'b000, 8'h00, 8'h00, 8'h00, 6'b011100}, // R3 equal
    {5'd3,  8'h01, 8'h80, 3'b000, 8'h7E, 8'h00, 8'h00, 6'b010010}, // R3 R2 borrow-in
    {5'd4,  8'h00, 8'h80, 3'b000, 8'h80, 8'h00, 8'h00, 6'b001011}, // R4 R2 min value
    {5'd4,  8'h00, 8'h00, 3'b000, 8'h00, 8'h00, 8'h00, 6'b011100}, // R4 zero
    {5'd5,  8'h00, 8'h5A, 3'b111, 8'hA5, 8'h00, 8'h00, 6'b011011}, // R4 R5 complement
    {5'd6,  8'hF0, 8'h0F, 3'b000, 8'h00, 8'h00, 8'h00, 6'b000100}, // R5 AND
    {5'd7,  8'h81, 8'h18, 3'b100, 8'h99, 8'h00, 8'h00, 6'b010001}, // R5 OR
    {5'd8,  8'hFF, 8'hFF, 3'b010, 8'h00, 8'h00, 8'h00, 6'b001100}, // R5 XOR
    {5'd9,  8'h00, 8'h01, 3'b000, 8'h80, 8'h00, 8'h00, 6'b000001}, // R6 rotate right
    {5'd10, 8'h00, 8'h80, 3'b000, 8'h01, 8'h00, 8'h00, 6'b000000}, // R6 rotate left
    {5'd11, 8'h00, 8'h01, 3'b000, 8'h00, 8'h00, 8'h00, 6'b010100}, // R6 right via C
    {5'd12, 8'h00, 8'h40, 3'b100, 8'h81, 8'h00, 8'h00, 6'b000001}, // R6 left via C
    {5'd13, 8'h00, 8'hA5, 3'b000, 8'h5A, 8'h00, 8'h00, 6'b000000}, // R7 swap
    {5'd15, 8'hFF, 8'hFF, 3'b101, 8'h01, 8'hFE, 8'h01, 6'b010010}, // R9 max product
    {5'd16, 8'h0F, 8'h10, 3'b000, 8'h10, 8'h00, 8'h00, 6'b100000}, // R10 greater
    {5'd16, 8'h10, 8'h0F, 3'b000, 8'h0F, 8'h00, 8'h00, 6'b000000}, // R10 not greater
    {5'd17, 8'h33, 8'h33, 3'b000, 8'h33, 8'h00, 8'h00, 6'b100000}, // R10 equal
    {5'd18, 8'hFF, 8'h00, 3'b000, 8'h00, 8'h00, 8'h00, 6'b100100}, // R10 less
    {5'd19, 8'h12, 8'hC3, 3'b111, 8'hC3, 8'h00, 8'h00, 6'b011011}  // R11 unused code
  };
  string vtag [NV] = '{"R1/R2", "R1", "R1", "R8", "R8", "R8", "R3", "R3", "R3/R2",
                       "R4/R2", "R4", "R4/R5", "R5", "R5", "R5", "R6", "R6", "R6",
                       "R6", "R7", "R9", "R10", "R10", "R10", "R10", "R11"};

  task automatic apply(input logic [4:0] o, input logic [7:0] w, input logic [7:0] f,
                       input logic c, input logic dc, input logic ov);
    @(posedge clk);
    op = o; w_opd = w; f_opd = f; c_in = c; dc_in = dc; ov_in = ov;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    op = 5'd0; w_opd = 8'h00; f_opd = 8'h00; c_in = 1'b0; dc_in = 1'b0; ov_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle state with all-zero inputs: R11 zero flag, R9 quiet product
    check("R11", "idle z", {31'd0, z_out}, 32'd1);
    check("R9", "idle prod", {16'd0, prod_hi, prod_lo}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [53:0] v;
      v = VECS[i];
      apply(v[53:49], v[48:41], v[40:33], v[32], v[31], v[30]);
      check(vtag[i], $sformatf("vec%0d result", i), {24'd0, result}, {24'd0, v[29:22]});
      check(vtag[i], $sformatf("vec%0d product", i), {16'd0, prod_hi, prod_lo},
            {16'd0, v[21:14], v[13:6]});
      check(vtag[i], $sformatf("vec%0d flags cmp,c,dc,z,ov,n", i),
            {26'd0, cmp_hit, c_out, dc_out, z_out, ov_out, n_out}, {26'd0, v[5:0]});
    end

    // R1 R2 R3 sweep of adder-class codes against an integer model
    for (int o = 0; o < 4; o++) begin
      for (int wi = 0; wi < 256; wi += 29) begin
        for (int fi = 0; fi < 256; fi += 23) begin
          for (int ci = 0; ci < 2; ci++) begin
            logic [7:0] bb;
            logic [8:0] full;
            logic [4:0] lo;
            logic       cc;
            int         sgn;
            bb   = (o >= 2) ? ~wi[7:0] : wi[7:0];
            cc   = (o == 0) ? 1'b0 : (o == 2) ? 1'b1 : ci[0];
            full = {1'b0, fi[7:0]} + {1'b0, bb} + {8'd0, cc};
            lo   = {1'b0, fi[3:0]} + {1'b0, bb[3:0]} + {4'd0, cc};
            sgn  = (fi[7] ? fi - 256 : fi) + (bb[7] ? int'(bb) - 256 : int'(bb)) + int'(cc);
            apply(o[4:0], wi[7:0], fi[7:0], ci[0], 1'b0, 1'b0);
            check((o < 2) ? "R1" : "R3", "sweep sum", {23'd0, c_out, result}, {23'd0, full});
            check((o < 2) ? "R1" : "R3", "sweep dc", {31'd0, dc_out}, {31'd0, lo[4]});
            check("R2", "sweep ov", {31'd0, ov_out}, (sgn > 127 || sgn < -128) ? 32'd1 : 32'd0);
          end
        end
      end
    end

    // R9 multiply sweep
    for (int wi = 0; wi < 256; wi += 7) begin
      for (int fi = 0; fi < 256; fi += 51) begin
        apply(5'd15, wi[7:0], fi[7:0], 1'b1, 1'b1, 1'b0);
        check("R9", "mul sweep", {16'd0, prod_hi, prod_lo}, wi * fi);
        check("R5", "mul holds c,dc,ov", {29'd0, c_out, dc_out, ov_out}, 32'd6);
      end
    end

    // R10 compare sweep, R11 z/n on the pass-through
    for (int k = 0; k < 256; k += 5) begin
      apply(5'd18, 8'h80, k[7:0], 1'b0, 1'b0, 1'b0);
      check("R10", "less than 0x80", {31'd0, cmp_hit}, (k < 128) ? 32'd1 : 32'd0);
      check("R11", "n on compare", {31'd0, n_out}, {31'd0, k[7]});
    end

    // R11 every unused code passes f and holds flags
    for (int o = 19; o < 32; o++) begin
      apply(o[4:0], 8'h5C, 8'h00, 1'b1, 1'b0, 1'b1);
      check("R11", "unused code", {20'd0, result, cmp_hit, c_out, dc_out, z_out, ov_out, n_out},
            {20'd0, 8'h00, 6'b010110});
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule